// File: doc/BRIEF.md
# Interval Timer with Snapshot Capture

A 32-bit down-counting interval timer reached through a small word-addressed register bus with 16-bit data. Software programs a 32-bit period as two 16-bit halves, starts and stops the count with self-clearing command bits, and chooses one-shot or auto-reload operation. Each time the count reaches zero, a sticky timeout flag is set. The flag drives a level interrupt when the interrupt is enabled.

Because the bus carries only 16 bits, a 32-bit count cannot be read in one access. A write of any value to the low snapshot register copies the whole live count into a 32-bit snapshot in one cycle. Software then reads the two halves at leisure and always sees one consistent value. With the period at all ones, the bitwise inverse of a snapshot is the number of cycles elapsed since the start.

Register offsets (word addresses): 0 status, 1 control, 2 period low, 3 period high, 4 snapshot low, 5 snapshot high. Offsets 6 and 7 are unused.

Top module: `interval_timer`

## Requirements
- R1: After reset the timer is stopped. Status reads 0 and control reads 0. Both period halves and the count hold 0xFFFF. Both snapshot halves read 0, and irq is low.
- R2: A read presents its data on rd_data one cycle after rd_en. rd_data is 0 in cycles with no read. Unused offsets and unused upper bits read as 0. Period low and high read back bits 15:0 and 31:16 of the period.
- R3: A write of any value to offset 4 captures the count held before that edge into both snapshot halves in one cycle: low at offset 4, high at offset 5.
- R4: While running, the count falls by one each cycle.
- R5: In one-shot mode (control bit 1 clear), a running count of zero sets the timeout flag on the next edge, stops the timer and holds the count at zero.
- R6: In continuous mode (control bit 1 set), a running count of zero sets the timeout flag and reloads the count from the period on the next edge, and the timer keeps running.
- R7: Control bit 2 starts the timer and bit 3 stops it. Stop wins when both are set. Both bits read back as 0, while bits 0 and 1 read back as written.
- R8: A write to either period half stops the timer and loads the count with the new 32-bit period.
- R9: Status bit 0 is the timeout flag and bit 1 is 1 while running. Any write to status clears the flag, and the clear wins over a timeout in the same cycle.
- R10: irq is high exactly while the timeout flag and the interrupt enable (control bit 0) are both set.
- R11: With both period halves at 0xFFFF, the inverse of a snapshot taken n cycles after the start gives n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Word address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, one cycle after rd_en |
| irq | output | 1 | Level interrupt |

## Verification
A write takes effect at the edge that samples it. The count then moves one step per further edge, and a zero count acts at the edge after it is reached. Read data appears one edge after the read strobe, and irq follows the flag and enable registers with no delay. Each driver task uses exactly one edge, so the bench can tally the edges between the start command and each snapshot or status read and predict the count exactly. The monitor compares read data at the falling edge after the edge that sampled the read.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int HW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [HW-1:0] wr_data,
  input  logic          rd_en,
  output logic [HW-1:0] rd_data,
  output logic          irq
);
  localparam int CW = 2 * HW;
  localparam logic [AW-1:0] A_STAT = 0, A_CTRL = 1, A_PLO = 2, A_PHI = 3, A_SLO = 4, A_SHI = 5;

  logic [CW-1:0] period, count, snap;
  logic          running, timeout, cont, ie;

  wire at_zero = running && (count == '0);
  wire wr_per  = wr_en && (addr == A_PLO || addr == A_PHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period  <= '1;
      count   <= '1;
      snap    <= '0;
      running <= 1'b0;
      timeout <= 1'b0;
      cont    <= 1'b0;
      ie      <= 1'b0;
    end else begin
      if (at_zero) begin
        timeout <= 1'b1;
        if (cont) count <= period;
        else      running <= 1'b0;
      end else if (running) begin
        count <= count - 1'b1;
      end
      if (wr_en) begin
        case (addr)
          A_STAT: timeout <= 1'b0;
          A_CTRL: begin
            ie   <= wr_data[0];
            cont <= wr_data[1];
            if (wr_data[3])      running <= 1'b0;
            else if (wr_data[2]) running <= 1'b1;
          end
          A_PLO: begin
            period[HW-1:0] <= wr_data;
            count          <= {period[CW-1:HW], wr_data};
            running        <= 1'b0;
          end
          A_PHI: begin
            period[CW-1:HW] <= wr_data;
            count           <= {wr_data, period[HW-1:0]};
            running         <= 1'b0;
          end
          A_SLO: snap <= count;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (!rd_en) rd_data <= '0;
    else begin
      case (addr)
        A_STAT:  rd_data <= {{(HW-2){1'b0}}, running, timeout};
        A_CTRL:  rd_data <= {{(HW-2){1'b0}}, cont, ie};
        A_PLO:   rd_data <= period[HW-1:0];
        A_PHI:   rd_data <= period[CW-1:HW];
        A_SLO:   rd_data <= snap[HW-1:0];
        A_SHI:   rd_data <= snap[CW-1:HW];
        default: rd_data <= '0;
      endcase
    end
  end

  assign irq = timeout & ie;

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SLO) |=> snap == $past(count));
  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (running && count != '0 && !wr_per) |=> count == $past(count) - 1'b1);
  a_r5_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !cont && !(wr_en && (addr == A_CTRL || wr_per))) |=> (!running && count == '0));
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && cont && !wr_per) |=> count == $past(period));
  a_r7_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL && wr_data[3]) |=> !running);
  a_r8_period_stops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_per |=> !running);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT) |=> !timeout);
endmodule

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        irq;

  int vecs = 0, errs = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  interval_timer dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    vecs++;
    if (act !== e) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", t, act, e);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (exp_q.size() != 0) begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          vecs++;
          if (rd_data !== e) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h", t, rd_data, e);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    chk(irq, 1'b0, "R1 irq");
    rd(0, 16'h0000, "R1 status");
    rd(1, 16'h0000, "R1 control");
    rd(2, 16'hFFFF, "R1 period lo");
    rd(3, 16'hFFFF, "R1 period hi");
    rd(4, 16'h0000, "R1 snap lo");
    rd(5, 16'h0000, "R1 snap hi");
    // R2 unused offset and idle bus
    rd(7, 16'h0000, "R2 unused offset");
    chk(rd_data == 16'h0, 1'b1, "R2 idle rd_data zero");

    // one-shot, period 10
    wr(3, 16'h0000);
    wr(2, 16'd10);
    wr(1, 16'h0004);
    idle(3);
    wr(4, 16'h1234);
    rd(4, 16'd7, "R3 R4 snapshot lo of running count");
    rd(5, 16'd0, "R3 snapshot hi");
    idle(5);
    rd(0, 16'h0001, "R5 one-shot timeout and stopped");
    chk(irq, 1'b0, "R10 irq masked");
    wr(4, 16'h0000);
    rd(4, 16'd0, "R5 count held at zero");
    wr(1, 16'h0001);
    chk(irq, 1'b1, "R10 irq with enable");
    rd(1, 16'h0001, "R7 start bit self-clears");
    wr(0, 16'h0000);
    chk(irq, 1'b0, "R9 irq after clear");
    rd(0, 16'h0000, "R9 status cleared");

    // continuous, period 3
    wr(3, 16'h0000);
    wr(2, 16'd3);
    wr(1, 16'h0007);
    idle(4);
    wr(4, 16'h0000);
    rd(4, 16'd3, "R6 reloaded from period");
    rd(0, 16'h0003, "R6 timeout set and still running");
    chk(irq, 1'b1, "R10 irq in continuous mode");
    wr(1, 16'h000E);
    chk(irq, 1'b0, "R10 irq with enable clear");
    rd(1, 16'h0002, "R7 stop and start bits read zero");
    rd(0, 16'h0001, "R7 stop wins over start");
    idle(3);
    wr(4, 16'h0000);
    rd(4, 16'd3, "R7 count frozen after stop");

    // period write stops
    wr(0, 16'h0000);
    wr(1, 16'h0004);
    idle(1);
    wr(2, 16'd100);
    rd(0, 16'h0000, "R8 period write stops timer");
    wr(4, 16'h0000);
    rd(4, 16'd100, "R8 count loaded from period");
    rd(2, 16'd100, "R2 period lo readback");
    rd(3, 16'd0, "R2 period hi readback");

    // full range elapsed count
    wr(3, 16'hFFFF);
    wr(2, 16'hFFFF);
    wr(1, 16'h0004);
    idle(9);
    wr(4, 16'h0000);
    rd(4, 16'hFFF6, "R11 snapshot lo inverts to 9");
    rd(5, 16'hFFFF, "R11 snapshot hi");

    idle(3);
    if (exp_q.size() != 0) begin
      errs++;
      $display("FAIL R2: got %0d pending reads expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule